// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives an external host byte-wide access to a small internal register file. The register file is addressed by a register pointer. SCL and SDA come in from open-drain pads and pass through synchronizers into the system clock domain. From there the block detects START, repeated START and STOP conditions. It checks the 7-bit device address, then either moves the pointer and writes registers, or returns register contents to the host. The pointer advances by one after every data byte.

The block has a single output, an SDA pull-down enable. The pad pulls the line low when this enable is high, and the block never drives SCL. The pointer is kept across STOP. A host can therefore set the pointer in a short write and later read from that point in a separate transaction, with no address phase. A host can also read at once after a repeated START. Any number of bytes may be moved in either direction, and the pointer wraps at the top of the address space.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, SDA is released, the pointer is 0x00 and every register holds 0x00. A first read with no address phase therefore returns 0x00.
- R2: Bytes are sent MSB first. The first byte after a START carries the 7-bit address in bits 7:1 and the direction in bit 0, where 1 means read. The block ACKs only its own address. On a mismatch it does not drive SDA and ignores all traffic until the next START or STOP.
- R3: In a write, the first byte after the address sets the pointer. Each later byte is stored at the pointer, the pointer then advances by one, and every byte is ACKed.
- R4: A write that carries only the pointer byte and then ends with STOP updates the pointer and leaves every register unchanged.
- R5: A read after a repeated START that follows a pointer write returns data starting at the register just addressed.
- R6: A read with no address phase starts at the current pointer. The pointer advances after each byte sent, and reading continues while the host ACKs.
- R7: After the host NACKs a read byte, the block keeps SDA released until the next START, even if SCL keeps toggling.
- R8: The pointer is 8 bits wide and wraps from 0xFF to 0x00, in both writes and reads.
- R9: Transfers of a single byte and of several bytes are handled alike in both directions.
- R10: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level sampled from the pad |
| sda_i | input | 1 | SDA level sampled from the pad |
| sda_oe | output | 1 | High to pull SDA low |

## Verification
The bench drives an address-only write followed by a separate read. A design that lost the pointer at STOP would return data from register 0. A design that treated the pointer byte as data would corrupt the old pointed register, and the bench reads that register back.

A burst across 0xFF shows whether the pointer wraps or spills out of range. After a NACK the bench keeps clocking SCL and expects an all-ones byte; a design that kept sending data would pull bits low. A foreign address is used for both a write and a read. A design that did not ignore it would ACK it, drive the bus, or overwrite a register that the bench checks afterwards.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes the bus lines and derives clock edges and bus conditions.
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus is high, so the pipes reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark bus conditions.
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_regfile.sv
// Register array: one write port, combinational read.
module i2c_tgt_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam int NREGS = 1 << AW;

  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/i2c_tgt_engine.sv
// Protocol engine: framing, address match, pointer, ACK and read data.
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] wr_data,
  output tgt_state_e        state_o
);

  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              pphase_q, pphase_d;
  logic              hack_q, hack_d;
  logic              oe_q, oe_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] sh_in;
  logic              byte_full;

  assign sh_in     = {sh_q[BYTE_W-2:0], sda_s};
  assign byte_full = (cnt_q == CNT_FULL);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    pphase_d = pphase_q;
    hack_d   = hack_q;
    oe_d     = oe_q;
    ptr_d    = ptr_q;
    wr_en    = 1'b0;

    unique case (state_q)
      ST_IDLE, ST_IGNORE: ;

      ST_ADDR: begin
        if (scl_rise) begin
          sh_d  = sh_in;
          cnt_d = cnt_q + CNT_W'(1);
        end else if (scl_fall && byte_full) begin
          if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
            state_d = ST_ADDR_ACK;
            oe_d    = 1'b1;
            rw_d    = sh_q[0];
            if (sh_q[0]) sh_d = rd_data;   // first read byte staged in the ACK slot
          end else begin
            state_d = ST_IGNORE;
          end
        end
      end

      ST_ADDR_ACK: begin
        if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            state_d = ST_RD_BYTE;
            oe_d    = ~sh_q[BYTE_W-1];
          end else begin
            state_d  = ST_WR_BYTE;
            oe_d     = 1'b0;
            pphase_d = 1'b1;
          end
        end
      end

      ST_WR_BYTE: begin
        if (scl_rise) begin
          sh_d  = sh_in;
          cnt_d = cnt_q + CNT_W'(1);
        end else if (scl_fall && byte_full) begin
          state_d = ST_WR_ACK;
          oe_d    = 1'b1;
          if (pphase_q) begin
            ptr_d    = sh_q[PTR_W-1:0];
            pphase_d = 1'b0;
          end else begin
            wr_en = 1'b1;
            ptr_d = ptr_q + PTR_W'(1);
          end
        end
      end

      ST_WR_ACK: begin
        if (scl_fall) begin
          state_d = ST_WR_BYTE;
          cnt_d   = '0;
          oe_d    = 1'b0;
        end
      end

      ST_RD_BYTE: begin
        if (scl_fall) begin
          if (cnt_q == CNT_LAST) begin
            state_d = ST_RD_ACK;
            oe_d    = 1'b0;
            ptr_d   = ptr_q + PTR_W'(1);
          end else begin
            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
            cnt_d = cnt_q + CNT_W'(1);
            oe_d  = ~sh_q[BYTE_W-2];
          end
        end
      end

      ST_RD_ACK: begin
        if (scl_rise) begin
          hack_d = ~sda_s;
        end else if (scl_fall) begin
          if (hack_q) begin
            state_d = ST_RD_BYTE;
            sh_d    = rd_data;
            cnt_d   = '0;
            oe_d    = ~rd_data[BYTE_W-1];
          end else begin
            state_d = ST_IGNORE;
            oe_d    = 1'b0;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase

    // Bus conditions override the byte engine.
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      wr_en   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      wr_en   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      pphase_q <= 1'b0;
      hack_q   <= 1'b0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rw_q     <= rw_d;
      pphase_q <= pphase_d;
      hack_q   <= hack_d;
      oe_q     <= oe_d;
      ptr_q    <= ptr_d;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr     = ptr_q;
  assign wr_data = sh_q;
  assign state_o = state_q;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h42,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              reg_we;
  logic [PTR_W-1:0]  reg_ptr;
  logic [BYTE_W-1:0] reg_wdata, reg_rdata;
  tgt_state_e        eng_state;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(reg_rdata), .sda_oe(sda_oe), .wr_en(reg_we), .ptr(reg_ptr),
    .wr_data(reg_wdata), .state_o(eng_state)
  );

  i2c_tgt_regfile #(.AW(PTR_W), .DW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_we), .addr(reg_ptr),
    .wr_data(reg_wdata), .rd_data(reg_rdata)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input tgt_state_e       state,
  input logic             wr_en,
  input logic [PTR_W-1:0] ptr
);

  // R10
  oe_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R2 R7
  quiet_state_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

  // R3 R8
  wr_ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + PTR_W'(1)));

  // R6
  rd_ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && $past(state) == ST_RD_BYTE) |-> (ptr == $past(ptr) + PTR_W'(1)));

  // R6
  ptr_move_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> !scl_s);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .state(eng_state), .wr_en(reg_we), .ptr(reg_ptr)
);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;

  localparam int Q = 10;
  localparam logic [7:0] AW_OK = 8'h84, AR_OK = 8'h85;
  localparam logic [7:0] AW_NO = 8'h86, AR_NO = 8'h87;

  logic clk, rst_n, scl_h, host_low;
  logic sda_oe, sda_line;
  int   n_chk, n_fail, oe_cycles, r10_viol;
  logic oe_prev;

  assign sda_line = ~(host_low | sda_oe);

  i2c_reg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Monitor: SDA drive activity and drive changes seen while SCL is high.
  always @(posedge clk) begin
    if (rst_n) begin
      if (sda_oe) oe_cycles <= oe_cycles + 1;
      if (scl_h && (sda_oe !== oe_prev)) r10_viol <= r10_viol + 1;
    end
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_h) begin
      host_low = 1'b0; q();
      scl_h = 1'b1; q();
    end
    q();
    host_low = 1'b1; q();
    scl_h = 1'b0; q();
  endtask

  task automatic bus_stop();
    host_low = 1'b1; q();
    scl_h = 1'b1; q();
    host_low = 1'b0; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; q();
      scl_h = 1'b1; q(); q();
      scl_h = 1'b0; q();
    end
    host_low = 1'b0; q();
    scl_h = 1'b1; q();
    ack = ~sda_line; q();
    scl_h = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      q();
      scl_h = 1'b1; q();
      b[i] = sda_line; q();
      scl_h = 1'b0; q();
    end
    host_low = give_ack; q();
    scl_h = 1'b1; q(); q();
    scl_h = 1'b0; q();
    host_low = 1'b0;
  endtask

  task automatic send_expect_ack(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    chk(a == 1'b1, req, a, 1);
  endtask

  task automatic recv_expect(input bit give_ack, input logic [7:0] exp, input string req);
    logic [7:0] b;
    recv_byte(give_ack, b);
    chk(b == exp, req, b, exp);
  endtask

  task automatic set_ptr_then_read(input logic [7:0] p);
    bus_start();
    send_expect_ack(AW_OK, "R2");
    send_expect_ack(p, "R3");
    bus_start();
    send_expect_ack(AR_OK, "R5");
  endtask

  // R1: reset state, then a current-address read of register 0.
  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    bus_start();
    send_expect_ack(AR_OK, "R2");
    recv_expect(1'b0, 8'h00, "R1");
    bus_stop();
  endtask

  // R3: pointer byte then a five-byte burst.
  task automatic t_write_burst();
    bus_start();
    send_expect_ack(AW_OK, "R2");
    send_expect_ack(8'h10, "R3");
    send_expect_ack(8'hA1, "R3");
    send_expect_ack(8'hA2, "R3");
    send_expect_ack(8'hA3, "R3");
    send_expect_ack(8'hA4, "R3");
    send_expect_ack(8'hA5, "R3");
    bus_stop();
  endtask

  // R5, R7: repeated START read, then NACK and continued clocking.
  task automatic t_rs_read();
    int base;
    set_ptr_then_read(8'h10);
    recv_expect(1'b1, 8'hA1, "R5");
    recv_expect(1'b1, 8'hA2, "R5");
    recv_expect(1'b0, 8'hA3, "R5");
    base = oe_cycles;
    recv_expect(1'b0, 8'hFF, "R7");
    chk(oe_cycles == base, "R7", oe_cycles - base, 0);
    bus_stop();
  endtask

  // R4, R6: pointer-only write, then separate reads with no address phase.
  task automatic t_ptr_only();
    bus_start();
    send_expect_ack(AW_OK, "R4");
    send_expect_ack(8'h11, "R4");
    bus_stop();
    bus_start();
    send_expect_ack(AR_OK, "R6");
    recv_expect(1'b1, 8'hA2, "R4");
    recv_expect(1'b1, 8'hA3, "R6");
    recv_expect(1'b0, 8'hA4, "R4");
    bus_stop();
    bus_start();
    send_expect_ack(AR_OK, "R6");
    recv_expect(1'b0, 8'hA5, "R6");
    bus_stop();
  endtask

  // R8: write and read across 0xFF -> 0x00.
  task automatic t_wrap();
    bus_start();
    send_expect_ack(AW_OK, "R8");
    send_expect_ack(8'hFE, "R8");
    send_expect_ack(8'h5A, "R8");
    send_expect_ack(8'hC3, "R8");
    send_expect_ack(8'h7E, "R8");
    bus_stop();
    set_ptr_then_read(8'hFE);
    recv_expect(1'b1, 8'h5A, "R8");
    recv_expect(1'b1, 8'hC3, "R8");
    recv_expect(1'b0, 8'h7E, "R8");
    bus_stop();
  endtask

  // R2: foreign address for write and read.
  task automatic t_mismatch();
    bit a;
    logic [7:0] b;
    int base;
    base = oe_cycles;
    bus_start();
    send_byte(AW_NO, a); chk(a == 1'b0, "R2", a, 0);
    send_byte(8'h10, a); chk(a == 1'b0, "R2", a, 0);
    send_byte(8'hEE, a); chk(a == 1'b0, "R2", a, 0);
    bus_stop();
    bus_start();
    send_byte(AR_NO, a); chk(a == 1'b0, "R2", a, 0);
    recv_byte(1'b0, b);  chk(b == 8'hFF, "R2", b, 8'hFF);
    bus_stop();
    chk(oe_cycles == base, "R2", oe_cycles - base, 0);
    set_ptr_then_read(8'h10);
    recv_expect(1'b0, 8'hA1, "R2");
    bus_stop();
  endtask

  // R9: single-byte write and single-byte read.
  task automatic t_single();
    bus_start();
    send_expect_ack(AW_OK, "R9");
    send_expect_ack(8'h20, "R9");
    send_expect_ack(8'h99, "R9");
    bus_stop();
    set_ptr_then_read(8'h20);
    recv_expect(1'b0, 8'h99, "R9");
    bus_stop();
  endtask

  initial begin
    n_chk = 0; n_fail = 0; oe_cycles = 0; r10_viol = 0; oe_prev = 1'b0;
    scl_h = 1'b1; host_low = 1'b0; rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_rs_read();
    t_ptr_only();
    t_wrap();
    t_mismatch();
    t_single();
    chk(r10_viol == 0, "R10", r10_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule